// File: doc/BRIEF.md
# Mailbox Command Dispatcher

A device-side engine that sits behind a host-visible command register and a doorbell. The host writes a 32-bit command word (a group byte, an operation byte and a payload length), then rings the doorbell. The engine forms a 16-bit opcode from the two bytes, looks it up in a fixed table of supported operations and compares the supplied length against the length that operation expects. Only when both checks pass does it start an external handler through a one-cycle start pulse and wait for the handler's done pulse, which carries an output length and a return code.

On completion the engine rewrites the command word (group and operation zeroed, length replaced by the result length), loads the status register with the return code and drops the doorbell, all on the same clock edge. A busy indication equal to the doorbell state tells the host when a command is in flight; command-word writes arriving while busy are discarded. The handler implementations are outside the block, and the lookup stage may be built as combinational or registered logic without changing the externally visible sequence.

Top module: `mbox_dispatch`

## Requirements
- R1: The command word is laid out as length in bits 31:16, group in bits 15:8 and operation in bits 7:0; the opcode presented to the handler is group*256 + operation, and the handler input length equals the supplied length.
- R2: An opcode absent from the table completes with status 0x03, never pulses the handler start, and leaves the supplied length in the length field.
- R3: A supported opcode whose supplied length differs from its expected length completes with status 0x16, never pulses the handler start, and leaves the supplied length in the length field.
- R4: The supported opcodes and expected lengths are 0x0100:1, 0x0101:variable, 0x0102:0, 0x0103:4, 0x0200:0, 0x0300:0, 0x0301:8, 0x0400:0, 0x0401:0x18, 0x4000:0, 0x4100:0, 0x4102:0, 0x4103:variable; every other opcode is unsupported.
- R5: A variable-length entry is encoded as an all-ones length and is accepted only when the supplied length is all ones (0xFFFF).
- R6: An accepted command produces exactly one handler start pulse; on completion group and operation read zero, the length field holds the handler's output length and the status holds the handler's return code (0x00 is success).
- R7: A handler output length above the payload capacity (default 256 bytes) is reported as exactly the capacity, with status 0x04 regardless of the handler's code.
- R8: Busy rises on the clock edge after a ring, stays high until completion, and falls on the same edge that updates the command word and status.
- R9: Command-word writes made while busy are ignored.
- R10: After reset busy is low, the command word and status read zero, and no handler start is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cmd_we | input | 1 | Host write strobe for the command word |
| host_cmd_wdata | input | LEN_W+16 | Command word written by the host |
| host_ring | input | 1 | Host doorbell ring strobe |
| busy | output | 1 | Doorbell state: command in flight |
| cmd_rdata | output | LEN_W+16 | Current command word |
| status_rdata | output | RC_W | Return code of the last command |
| hdl_start | output | 1 | One-cycle handler start pulse |
| hdl_opcode | output | 16 | Opcode of the command being executed |
| hdl_in_len | output | LEN_W | Supplied payload length |
| hdl_done | input | 1 | Handler completion pulse |
| hdl_out_len | input | LEN_W | Handler output length, valid with hdl_done |
| hdl_rc | input | RC_W | Handler return code, valid with hdl_done |

## Verification
The assertions take for granted that the handler raises its done pulse only after a start pulse and only while the engine is waiting for it, and that it never answers twice for one start. The handler model in the stimulus honours this by arming only on an observed start and firing done a chosen number of cycles later, once. Host strobes are driven between clock edges, and length mismatches, unknown opcodes, the all-ones marker, oversize results and writes during busy are each exercised against values worked out from the table.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   typedef enum logic [7:0] {
      RC_OK       = 8'h00,
      RC_UNSUP    = 8'h03,
      RC_INTERNAL = 8'h04,
      RC_BAD_LEN  = 8'h16
   } rc_e;

   // One table entry: hit flag, variable-length flag, fixed length.
   typedef struct packed {
      logic        hit;
      logic        var_len;
      logic [15:0] len;
   } tab_ent_t;

   function automatic tab_ent_t tab_lookup(input logic [15:0] opc);
      tab_ent_t e;
      e = '{hit: 1'b1, var_len: 1'b0, len: 16'd0};
      case (opc)
         16'h0100: e.len = 16'd1;
         16'h0101: e.var_len = 1'b1;
         16'h0102: e.len = 16'd0;
         16'h0103: e.len = 16'd4;
         16'h0200: e.len = 16'd0;
         16'h0300: e.len = 16'd0;
         16'h0301: e.len = 16'd8;
         16'h0400: e.len = 16'd0;
         16'h0401: e.len = 16'h18;
         16'h4000: e.len = 16'd0;
         16'h4100: e.len = 16'd0;
         16'h4102: e.len = 16'd0;
         16'h4103: e.var_len = 1'b1;
         default:  e.hit = 1'b0;
      endcase
      return e;
   endfunction

endpackage

// File: rtl/mbox_cmd_table.sv
module mbox_cmd_table #(
   parameter int LEN_W      = 16,
   parameter bit LOOKUP_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [15:0]      opcode,
   output logic             hit,
   output logic [LEN_W-1:0] exp_len
);
   import mbox_pkg::*;

   localparam logic [LEN_W-1:0] VAR_MARK = '1;

   tab_ent_t         ent;
   logic             hit_c;
   logic [LEN_W-1:0] len_c;

   always_comb begin
      ent   = tab_lookup(opcode);
      hit_c = ent.hit;
      len_c = ent.var_len ? VAR_MARK : LEN_W'(ent.len);
   end

   generate
      if (LOOKUP_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hit     <= 1'b0;
               exp_len <= '0;
            end else begin
               hit     <= hit_c;
               exp_len <= len_c;
            end
         end
      end else begin : g_comb
         assign hit     = hit_c;
         assign exp_len = len_c;
      end
   endgenerate

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs #(
   parameter int LEN_W = 16,
   parameter int RC_W  = 8,
   localparam int CMD_W = LEN_W + 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [CMD_W-1:0] host_wdata,
   input  logic             host_ring,
   input  logic             fin,
   input  logic [LEN_W-1:0] fin_len,
   input  logic [RC_W-1:0]  fin_rc,
   output logic             doorbell,
   output logic [CMD_W-1:0] cmd_q,
   output logic [RC_W-1:0]  status_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         doorbell <= 1'b0;
         cmd_q    <= '0;
         status_q <= '0;
      end else if (fin) begin
         doorbell <= 1'b0;
         cmd_q    <= {fin_len, 16'h0000};
         status_q <= fin_rc;
      end else if (!doorbell) begin
         if (host_we)   cmd_q    <= host_wdata;
         if (host_ring) doorbell <= 1'b1;
      end
   end

   // R9
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (doorbell && host_we && !fin) |=> $stable(cmd_q));

   // R8
   ring_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!doorbell && host_ring) |=> doorbell);

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq #(
   parameter int LEN_W       = 16,
   parameter int RC_W        = 8,
   parameter int PAYLOAD_MAX = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             doorbell,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic             tab_hit,
   input  logic [LEN_W-1:0] tab_exp_len,
   input  logic             hdl_done,
   input  logic [LEN_W-1:0] hdl_out_len,
   input  logic [RC_W-1:0]  hdl_rc,
   output logic             hdl_start,
   output logic             fin,
   output logic [LEN_W-1:0] fin_len,
   output logic [RC_W-1:0]  fin_rc
);
   import mbox_pkg::*;

   localparam logic [LEN_W-1:0] CAP = LEN_W'(PAYLOAD_MAX);

   typedef enum logic [2:0] {S_IDLE, S_LOOK, S_START, S_WAIT, S_DONE} st_e;

   st_e              st;
   logic [LEN_W-1:0] res_len;
   logic [RC_W-1:0]  res_rc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         res_len <= '0;
         res_rc  <= '0;
      end else begin
         case (st)
            S_IDLE: if (doorbell) st <= S_LOOK;
            S_LOOK: begin
               if (!tab_hit) begin
                  res_rc  <= RC_W'(RC_UNSUP);
                  res_len <= cmd_len;
                  st      <= S_DONE;
               end else if (cmd_len != tab_exp_len) begin
                  res_rc  <= RC_W'(RC_BAD_LEN);
                  res_len <= cmd_len;
                  st      <= S_DONE;
               end else begin
                  st <= S_START;
               end
            end
            S_START: st <= S_WAIT;
            S_WAIT: if (hdl_done) begin
               if (hdl_out_len > CAP) begin
                  res_len <= CAP;
                  res_rc  <= RC_W'(RC_INTERNAL);
               end else begin
                  res_len <= hdl_out_len;
                  res_rc  <= hdl_rc;
               end
               st <= S_DONE;
            end
            S_DONE:  st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign hdl_start = (st == S_START);
   assign fin       = (st == S_DONE);
   assign fin_len   = res_len;
   assign fin_rc    = res_rc;

   // R6
   start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdl_start |=> !hdl_start);

   // R3
   start_len_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hdl_start |-> (tab_hit && cmd_len == tab_exp_len));

   // R7
   result_capped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WAIT && hdl_done) |=> (res_len <= CAP));

   // R8
   busy_during_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE) |-> doorbell);

endmodule

// File: rtl/mbox_dispatch.sv
module mbox_dispatch #(
   parameter int LEN_W       = 16,
   parameter int RC_W        = 8,
   parameter int PAYLOAD_MAX = 256,
   parameter bit LOOKUP_REG  = 1'b1,
   localparam int CMD_W = LEN_W + 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_cmd_we,
   input  logic [CMD_W-1:0] host_cmd_wdata,
   input  logic             host_ring,
   output logic             busy,
   output logic [CMD_W-1:0] cmd_rdata,
   output logic [RC_W-1:0]  status_rdata,
   output logic             hdl_start,
   output logic [15:0]      hdl_opcode,
   output logic [LEN_W-1:0] hdl_in_len,
   input  logic             hdl_done,
   input  logic [LEN_W-1:0] hdl_out_len,
   input  logic [RC_W-1:0]  hdl_rc
);
   import mbox_pkg::*;

   generate
      if (LEN_W < 8)  begin : g_bad_len $error("LEN_W too small for table"); end
      if (RC_W < 5)   begin : g_bad_rc  $error("RC_W cannot hold return codes"); end
      if (PAYLOAD_MAX < 1 || PAYLOAD_MAX >= (2**LEN_W) - 1) begin : g_bad_cap
         $error("PAYLOAD_MAX out of range for LEN_W");
      end
   endgenerate

   logic             doorbell;
   logic [CMD_W-1:0] cmd_q;
   logic             tab_hit;
   logic [LEN_W-1:0] tab_exp_len;
   logic             fin;
   logic [LEN_W-1:0] fin_len;
   logic [RC_W-1:0]  fin_rc;

   mbox_regs #(.LEN_W(LEN_W), .RC_W(RC_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_cmd_we), .host_wdata(host_cmd_wdata), .host_ring(host_ring),
      .fin(fin), .fin_len(fin_len), .fin_rc(fin_rc),
      .doorbell(doorbell), .cmd_q(cmd_q), .status_q(status_rdata)
   );

   mbox_cmd_table #(.LEN_W(LEN_W), .LOOKUP_REG(LOOKUP_REG)) u_table (
      .clk(clk), .rst_n(rst_n), .opcode(cmd_q[15:0]),
      .hit(tab_hit), .exp_len(tab_exp_len)
   );

   mbox_seq #(.LEN_W(LEN_W), .RC_W(RC_W), .PAYLOAD_MAX(PAYLOAD_MAX)) u_seq (
      .clk(clk), .rst_n(rst_n), .doorbell(doorbell),
      .cmd_len(cmd_q[CMD_W-1:16]), .tab_hit(tab_hit), .tab_exp_len(tab_exp_len),
      .hdl_done(hdl_done), .hdl_out_len(hdl_out_len), .hdl_rc(hdl_rc),
      .hdl_start(hdl_start), .fin(fin), .fin_len(fin_len), .fin_rc(fin_rc)
   );

   assign busy       = doorbell;
   assign cmd_rdata  = cmd_q;
   assign hdl_opcode = cmd_q[15:0];
   assign hdl_in_len = cmd_q[CMD_W-1:16];

   // R2
   unsup_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && !tab_hit) |-> (fin_rc == RC_W'(RC_UNSUP)));

   // R8
   busy_fall_on_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(doorbell) |-> $past(fin));

   // R6
   fin_clears_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> (cmd_q[15:0] == 16'h0000 && !doorbell));

endmodule

// File: tb/mbox_dispatch_tb.sv
module mbox_dispatch_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_cmd_we = 1'b0;
   logic [31:0] host_cmd_wdata = '0;
   logic        host_ring = 1'b0;
   logic        busy;
   logic [31:0] cmd_rdata;
   logic [7:0]  status_rdata;
   logic        hdl_start;
   logic [15:0] hdl_opcode;
   logic [15:0] hdl_in_len;
   logic        hdl_done = 1'b0;
   logic [15:0] hdl_out_len = '0;
   logic [7:0]  hdl_rc = '0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   mbox_dispatch u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_cmd_we(host_cmd_we), .host_cmd_wdata(host_cmd_wdata), .host_ring(host_ring),
      .busy(busy), .cmd_rdata(cmd_rdata), .status_rdata(status_rdata),
      .hdl_start(hdl_start), .hdl_opcode(hdl_opcode), .hdl_in_len(hdl_in_len),
      .hdl_done(hdl_done), .hdl_out_len(hdl_out_len), .hdl_rc(hdl_rc)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Issue one command; the handler model answers h_dly cycles after start.
   task automatic run_cmd(input logic [7:0] grp, input logic [7:0] op,
                          input logic [15:0] len, input logic [15:0] h_len,
                          input logic [7:0] h_rc, input int h_dly,
                          input logic [15:0] e_len, input logic [7:0] e_rc,
                          input bit e_start, input bit poke, input string req);
      int starts = 0;
      int n = 0;
      int cnt = 0;
      bit pend = 0;
      @(negedge clk);
      host_cmd_we = 1'b1; host_cmd_wdata = {len, grp, op}; host_ring = 1'b1;
      @(negedge clk);
      host_cmd_we = 1'b0; host_ring = 1'b0;
      chk(busy == 1'b1, "R8 busy after ring", busy, 1);
      if (poke) begin
         host_cmd_we = 1'b1; host_cmd_wdata = 32'hDEAD_BEEF;
         @(negedge clk);
         host_cmd_we = 1'b0;
         chk(cmd_rdata == {len, grp, op}, "R9 write while busy", cmd_rdata, {len, grp, op});
      end
      while (busy && n < 1000) begin
         hdl_done = 1'b0;
         if (pend) begin
            if (cnt == 0) begin
               hdl_done = 1'b1; hdl_out_len = h_len; hdl_rc = h_rc; pend = 0;
            end else cnt--;
         end
         if (hdl_start) begin
            starts++;
            chk(hdl_opcode == {grp, op}, "R1 opcode", hdl_opcode, {grp, op});
            chk(hdl_in_len == len, "R1 in length", hdl_in_len, len);
            pend = 1; cnt = h_dly;
         end
         @(negedge clk);
         n++;
      end
      hdl_done = 1'b0;
      chk(n < 1000, {req, " completion"}, n, 1000);
      chk(starts == (e_start ? 1 : 0), {req, " start count"}, starts, e_start);
      chk(status_rdata == e_rc, {req, " status"}, status_rdata, e_rc);
      chk(cmd_rdata == {e_len, 16'h0000}, {req, " command word"}, cmd_rdata, {e_len, 16'h0000});
   endtask

   task automatic t_reset();
      chk(busy == 1'b0, "R10 busy", busy, 0);
      chk(cmd_rdata == '0, "R10 cmd", cmd_rdata, 0);
      chk(status_rdata == '0, "R10 status", status_rdata, 0);
      chk(hdl_start == 1'b0, "R10 start", hdl_start, 0);
   endtask

   task automatic t_basic();
      run_cmd(8'h03, 8'h00, 16'd0, 16'd8, 8'h00, 0, 16'd8, 8'h00, 1, 0, "R6 0x0300");
      run_cmd(8'h01, 8'h03, 16'd4, 16'd0, 8'h00, 3, 16'd0, 8'h00, 1, 0, "R6 0x0103");
      run_cmd(8'h04, 8'h00, 16'd0, 16'd2, 8'h06, 1, 16'd2, 8'h06, 1, 0, "R6 rc pass");
   endtask

   task automatic t_errors();
      run_cmd(8'h01, 8'h03, 16'd5, 16'd9, 8'h00, 0, 16'd5, 8'h16, 0, 0, "R3 0x0103 len5");
      run_cmd(8'h01, 8'h04, 16'd0, 16'd9, 8'h00, 0, 16'd0, 8'h03, 0, 0, "R2 0x0104");
      run_cmd(8'h41, 8'h01, 16'd7, 16'd9, 8'h00, 0, 16'd7, 8'h03, 0, 0, "R2 0x4101");
      run_cmd(8'hFF, 8'hFF, 16'hFFFF, 16'd9, 8'h00, 0, 16'hFFFF, 8'h03, 0, 0, "R2 0xFFFF");
   endtask

   task automatic t_variable();
      run_cmd(8'h01, 8'h01, 16'hFFFF, 16'd4, 8'h00, 0, 16'd4, 8'h00, 1, 0, "R5 0x0101 marker");
      run_cmd(8'h01, 8'h01, 16'd3, 16'd4, 8'h00, 0, 16'd3, 8'h16, 0, 0, "R5 0x0101 len3");
      run_cmd(8'h41, 8'h03, 16'hFFFF, 16'd0, 8'h00, 2, 16'd0, 8'h00, 1, 0, "R5 0x4103 marker");
      run_cmd(8'h41, 8'h03, 16'hFFFE, 16'd0, 8'h00, 2, 16'hFFFE, 8'h16, 0, 0, "R5 0x4103 len");
   endtask

   task automatic t_clamp();
      run_cmd(8'h03, 8'h00, 16'd0, 16'd300, 8'h00, 0, 16'd256, 8'h04, 1, 0, "R7 oversize");
      run_cmd(8'h03, 8'h00, 16'd0, 16'd257, 8'h06, 0, 16'd256, 8'h04, 1, 0, "R7 257");
      run_cmd(8'h03, 8'h00, 16'd0, 16'd256, 8'h00, 0, 16'd256, 8'h00, 1, 0, "R7 at cap");
   endtask

   task automatic t_busy_write();
      run_cmd(8'h02, 8'h00, 16'd0, 16'd16, 8'h00, 5, 16'd16, 8'h00, 1, 1, "R9 poke");
   endtask

   task automatic t_sweep();
      logic [15:0] opc [13] = '{16'h0100, 16'h0101, 16'h0102, 16'h0103, 16'h0200,
                                16'h0300, 16'h0301, 16'h0400, 16'h0401, 16'h4000,
                                16'h4100, 16'h4102, 16'h4103};
      logic [15:0] eln [13] = '{16'd1, 16'hFFFF, 16'd0, 16'd4, 16'd0, 16'd0, 16'd8,
                                16'd0, 16'h18, 16'd0, 16'd0, 16'd0, 16'hFFFF};
      for (int i = 0; i < 13; i++) begin
         logic [15:0] bad;
         bad = (eln[i] == 16'hFFFF) ? 16'd0 : eln[i] + 16'd1;
         run_cmd(opc[i][15:8], opc[i][7:0], eln[i], 16'd1, 8'h00, 0,
                 16'd1, 8'h00, 1, 0, "R4 accept");
         run_cmd(opc[i][15:8], opc[i][7:0], bad, 16'd1, 8'h00, 0,
                 bad, 8'h16, 0, 0, "R4 reject");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_errors();
      t_variable();
      t_clamp();
      t_busy_write();
      t_sweep();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule